// File: doc/BRIEF.md
# Adaptive Sparing Escalation Controller

This controller decides how much of a memory rank must run in virtual lockstep after devices start to fail. It sees threshold-crossing events from the error-correction logic. Each event is tagged with the rank, the device and the bank that crossed its correctable-error threshold. Until the first such strike the channel runs normally, with no lockstep and no copy overhead. The first strike puts only the failing bank into lockstep with a buddy bank and asks the data mover to copy that bank to the spare device.

A later strike in another bank of the same rank undoes the bank-level lockstep and rebuilds it at rank level. The whole failing device is then copied to the spare. Once rank-level sparing is in place, a failure of a second device in that rank switches on the plus-one correction stage. The controller also has a non-adaptive path: when bank/rank adaptation is off and plus-one is on, the first failure leads to a whole-device spare and then to plus-one.

Strikes that arrive while a copy is running wait in a single holding slot. Configurations that the scheme does not allow keep the controller idle and raise an error flag. The copy itself is done by a separate engine through a start/done handshake.

Top module: `spare_escalation_ctrl`

## Requirements
- R1: After reset, mode is 0 (normal) and copy_start, copy_whole, bank_vls, rank_vls, plus_one, mapped_valid and cfg_err are all 0.
- R2: In normal mode, with adaptive sparing on and no conflict, a strike moves mode to 1 (bank copy) on the next clock edge. mapped_rank, mapped_dev and mapped_bank load the strike's fields, mapped_valid goes to 1, and bank_vls and copy_start go to 1 with copy_whole 0. copy_start stays high until copy_done, and then mode goes to 2 (bank lockstep) with copy_start low and bank_vls still high.
- R3: In mode 2, a strike on the mapped rank in a bank other than mapped_bank moves mode to 3 (rank copy). bank_vls drops to 0, rank_vls goes to 1, and copy_start and copy_whole go to 1, while the mapped fields keep their values. After copy_done, mode goes to 4 (rank lockstep).
- R4: In mode 2, a strike on the mapped bank, or on any other rank, has no effect.
- R5: In mode 4, with plus-one enabled, a strike on the mapped rank naming a device other than mapped_dev moves mode to 5 (plus-one) and plus_one goes to 1. A strike naming mapped_dev, or any strike while plus-one is disabled, has no effect.
- R6: With adaptive sparing off and plus-one on, a strike in normal mode moves mode to 3 with copy_whole 1 and rank_vls 0. After copy_done, mode goes straight to 5.
- R7: With adaptive sparing and plus-one both off, strikes leave the controller in mode 0.
- R8: A conflict exists when adaptive sparing is on together with an x8 device type, mirroring or rank sparing, or when plus-one is on together with mirroring or rank sparing. cfg_err shows the conflict one clock after the configuration is applied, and strikes during a conflict leave mode at 0.
- R9: A strike that arrives during a copy (mode 1 or 3) is held in a single slot and acted on one cycle after the copy completes. A further strike that arrives while the slot is full is dropped.
- R10: Mode 5 is terminal: strikes and copy_done change neither the mode nor the mapped fields.
- R11: copy_done outside a copy mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_adaptive_en | input | 1 | Enables bank/rank adaptive lockstep sparing |
| cfg_plus_one_en | input | 1 | Enables the plus-one correction stage |
| cfg_x8 | input | 1 | Devices are x8 (1) rather than x4 (0) |
| cfg_mirror_en | input | 1 | Memory mirroring is enabled |
| cfg_rank_spare_en | input | 1 | Whole-rank sparing is enabled |
| strike_valid | input | 1 | A threshold-crossing event is presented this cycle |
| strike_rank | input | RANK_W | Rank of the event |
| strike_dev | input | DEV_W | Device of the event |
| strike_bank | input | BANK_W | Bank of the event |
| copy_done | input | 1 | The data mover has finished the requested copy |
| mode | output | 3 | 0 normal, 1 bank copy, 2 bank lockstep, 3 rank copy, 4 rank lockstep, 5 plus-one |
| copy_start | output | 1 | Copy request, held until copy_done |
| copy_whole | output | 1 | The request covers the whole device (1) or a single bank (0) |
| bank_vls | output | 1 | Bank-level lockstep active |
| rank_vls | output | 1 | Rank-level lockstep active |
| plus_one | output | 1 | Plus-one correction active |
| cfg_err | output | 1 | Configuration conflict |
| mapped_valid | output | 1 | Mapped-out fields are valid |
| mapped_rank | output | RANK_W | Rank holding the mapped-out device |
| mapped_dev | output | DEV_W | Mapped-out device |
| mapped_bank | output | BANK_W | Bank of the first strike |

## Verification
The hardest case to reach from the ports is a strike that arrives during a copy, gets held, and then has to escalate the mode one cycle after copy_done, while a second strike during the same copy must be dropped. The bench first drives a bank copy. During that copy it presents a promoting strike and then a plus-one-worthy strike on back-to-back cycles. It then checks that the mode passes through bank lockstep and rank copy, and that it never reaches plus-one from the dropped event. A sweep over all 32 configuration-bit combinations checks the conflict flag and the reaction to the first strike against a formula computed in the bench.

// File: rtl/spare_pkg.sv
// Shared types for the sparing escalation controller.
// Assumes a 3-bit mode code seen at the top-level ports.
package spare_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL    = 3'd0,
        ST_BANK_COPY = 3'd1,
        ST_BANK_VLS  = 3'd2,
        ST_RANK_COPY = 3'd3,
        ST_RANK_VLS  = 3'd4,
        ST_PLUS_ONE  = 3'd5
    } esc_state_t;
endpackage

// File: rtl/cfg_guard.sv
// Configuration legality check. Flags enables that cannot coexist.
// Assumes the configuration is quasi-static; the conflict is combinational
// for the state machine and registered for the output flag.
module cfg_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic adaptive_en,
    input  logic plus_one_en,
    input  logic dev_x8,
    input  logic mirror_en,
    input  logic rank_spare_en,
    output logic conflict,
    output logic err_q
);
    logic redundancy_clash;

    // Combinational legality decode.
    always_comb begin
        redundancy_clash = mirror_en | rank_spare_en;
        conflict = (adaptive_en & (dev_x8 | redundancy_clash))
                 | (plus_one_en & redundancy_clash);
    end

    // Registered error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= conflict;
    end
endmodule

// File: rtl/strike_hold.sv
// One-entry holding slot for strikes. While the controller is busy copying,
// the first strike is captured and later ones are dropped. When the
// controller is idle, a held strike takes priority and a live strike that
// arrives in the same cycle takes its place in the slot.
module strike_hold #(
    parameter int RANK_W = 3,
    parameter int DEV_W  = 5,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              in_valid,
    input  logic [RANK_W-1:0] in_rank,
    input  logic [DEV_W-1:0]  in_dev,
    input  logic [BANK_W-1:0] in_bank,
    output logic              eff_valid,
    output logic [RANK_W-1:0] eff_rank,
    output logic [DEV_W-1:0]  eff_dev,
    output logic [BANK_W-1:0] eff_bank
);
    logic              held_v;
    logic [RANK_W-1:0] held_rank;
    logic [DEV_W-1:0]  held_dev;
    logic [BANK_W-1:0] held_bank;
    logic              load, consume;

    // Decide capture and release of the slot.
    always_comb begin
        load    = in_valid & (busy ? ~held_v : held_v);
        consume = ~busy & held_v;
    end

    // Slot storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v    <= 1'b0;
            held_rank <= '0;
            held_dev  <= '0;
            held_bank <= '0;
        end else if (load) begin
            held_v    <= 1'b1;
            held_rank <= in_rank;
            held_dev  <= in_dev;
            held_bank <= in_bank;
        end else if (consume) begin
            held_v    <= 1'b0;
        end
    end

    // Strike presented to the state machine.
    always_comb begin
        eff_valid = ~busy & (held_v | in_valid);
        eff_rank  = held_v ? held_rank : in_rank;
        eff_dev   = held_v ? held_dev  : in_dev;
        eff_bank  = held_v ? held_bank : in_bank;
    end
endmodule

// File: rtl/escalate_fsm.sv
// Escalation state machine. It moves from normal operation to bank lockstep,
// then to rank lockstep, then to plus-one, and records the mapped-out
// location. Assumes strikes reach it only when it is not in a copy state.
module escalate_fsm
    import spare_pkg::*;
#(
    parameter int RANK_W = 3,
    parameter int DEV_W  = 5,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adaptive_en,
    input  logic              plus_one_en,
    input  logic              conflict,
    input  logic              sv,
    input  logic [RANK_W-1:0] s_rank,
    input  logic [DEV_W-1:0]  s_dev,
    input  logic [BANK_W-1:0] s_bank,
    input  logic              copy_done,
    output esc_state_t        state,
    output logic              via_adaptive,
    output logic              map_v,
    output logic [RANK_W-1:0] map_rank,
    output logic [DEV_W-1:0]  map_dev,
    output logic [BANK_W-1:0] map_bank
);
    esc_state_t nxt;
    logic       capture;
    logic       same_rank;

    // Next-state decision.
    always_comb begin
        nxt       = state;
        capture   = 1'b0;
        same_rank = (s_rank == map_rank);
        case (state)
            ST_NORMAL: begin
                if (sv && !conflict) begin
                    if (adaptive_en) begin
                        nxt = ST_BANK_COPY; capture = 1'b1;
                    end else if (plus_one_en) begin
                        nxt = ST_RANK_COPY; capture = 1'b1;
                    end
                end
            end
            ST_BANK_COPY: if (copy_done) nxt = ST_BANK_VLS;
            ST_BANK_VLS:  if (sv && same_rank && s_bank != map_bank) nxt = ST_RANK_COPY;
            ST_RANK_COPY: if (copy_done) nxt = via_adaptive ? ST_RANK_VLS : ST_PLUS_ONE;
            ST_RANK_VLS:  if (sv && plus_one_en && same_rank && s_dev != map_dev) nxt = ST_PLUS_ONE;
            ST_PLUS_ONE:  nxt = ST_PLUS_ONE;
            default:      nxt = ST_NORMAL;
        endcase
    end

    // State and mapped-out location registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_NORMAL;
            via_adaptive <= 1'b0;
            map_v        <= 1'b0;
            map_rank     <= '0;
            map_dev      <= '0;
            map_bank     <= '0;
        end else begin
            state <= nxt;
            if (capture) begin
                via_adaptive <= adaptive_en;
                map_v        <= 1'b1;
                map_rank     <= s_rank;
                map_dev      <= s_dev;
                map_bank     <= s_bank;
            end
        end
    end
endmodule

// File: rtl/spare_escalation_ctrl.sv
// Top of the adaptive sparing escalation controller. It joins the
// configuration guard, the strike holding slot and the escalation state
// machine, and decodes the mode flags. The data mover is external.
module spare_escalation_ctrl
    import spare_pkg::*;
#(
    parameter int RANK_W = 3,
    parameter int DEV_W  = 5,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_adaptive_en,
    input  logic              cfg_plus_one_en,
    input  logic              cfg_x8,
    input  logic              cfg_mirror_en,
    input  logic              cfg_rank_spare_en,
    input  logic              strike_valid,
    input  logic [RANK_W-1:0] strike_rank,
    input  logic [DEV_W-1:0]  strike_dev,
    input  logic [BANK_W-1:0] strike_bank,
    input  logic              copy_done,
    output logic [2:0]        mode,
    output logic              copy_start,
    output logic              copy_whole,
    output logic              bank_vls,
    output logic              rank_vls,
    output logic              plus_one,
    output logic              cfg_err,
    output logic              mapped_valid,
    output logic [RANK_W-1:0] mapped_rank,
    output logic [DEV_W-1:0]  mapped_dev,
    output logic [BANK_W-1:0] mapped_bank
);
    esc_state_t        state;
    logic              conflict, via_adaptive, busy;
    logic              eff_v;
    logic [RANK_W-1:0] eff_rank;
    logic [DEV_W-1:0]  eff_dev;
    logic [BANK_W-1:0] eff_bank;

    cfg_guard u_guard (
        .clk(clk), .rst_n(rst_n),
        .adaptive_en(cfg_adaptive_en), .plus_one_en(cfg_plus_one_en),
        .dev_x8(cfg_x8), .mirror_en(cfg_mirror_en), .rank_spare_en(cfg_rank_spare_en),
        .conflict(conflict), .err_q(cfg_err)
    );

    // Copy states block new strikes from the state machine.
    always_comb busy = (state == ST_BANK_COPY) || (state == ST_RANK_COPY);

    strike_hold #(.RANK_W(RANK_W), .DEV_W(DEV_W), .BANK_W(BANK_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .in_valid(strike_valid), .in_rank(strike_rank), .in_dev(strike_dev), .in_bank(strike_bank),
        .eff_valid(eff_v), .eff_rank(eff_rank), .eff_dev(eff_dev), .eff_bank(eff_bank)
    );

    escalate_fsm #(.RANK_W(RANK_W), .DEV_W(DEV_W), .BANK_W(BANK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .adaptive_en(cfg_adaptive_en), .plus_one_en(cfg_plus_one_en), .conflict(conflict),
        .sv(eff_v), .s_rank(eff_rank), .s_dev(eff_dev), .s_bank(eff_bank),
        .copy_done(copy_done), .state(state), .via_adaptive(via_adaptive),
        .map_v(mapped_valid), .map_rank(mapped_rank), .map_dev(mapped_dev), .map_bank(mapped_bank)
    );

    // Mode flag decode.
    always_comb begin
        mode       = state;
        copy_start = busy;
        copy_whole = (state == ST_RANK_COPY);
        bank_vls   = (state == ST_BANK_COPY) || (state == ST_BANK_VLS);
        rank_vls   = via_adaptive && ((state == ST_RANK_COPY) || (state == ST_RANK_VLS)
                                      || (state == ST_PLUS_ONE));
        plus_one   = (state == ST_PLUS_ONE);
    end
endmodule

// File: rtl/spare_escalation_chk.sv
// Property checker for the sparing escalation controller, bound to the top.
module spare_escalation_chk #(
    parameter int RANK_W = 3,
    parameter int DEV_W  = 5,
    parameter int BANK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_adaptive_en,
    input logic              cfg_x8,
    input logic              cfg_mirror_en,
    input logic              cfg_rank_spare_en,
    input logic              copy_done,
    input logic [2:0]        mode,
    input logic              copy_start,
    input logic              copy_whole,
    input logic              bank_vls,
    input logic              rank_vls,
    input logic              plus_one,
    input logic              mapped_valid,
    input logic [RANK_W-1:0] mapped_rank,
    input logic [DEV_W-1:0]  mapped_dev,
    input logic [BANK_W-1:0] mapped_bank
);
    // R2: a copy request is held until done, with the location unchanged.
    p_copy_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_start && !copy_done) |=> (copy_start && $stable(mapped_dev) && $stable(mapped_bank)));

    // R3: bank lockstep only stays or escalates to rank copy.
    p_bank_escalate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |=> (mode == 3'd2 || mode == 3'd3));

    // R3: the two lockstep scopes never overlap.
    p_no_scope_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_vls && rank_vls));

    // R3: a rank copy covers the whole device.
    p_rank_copy_whole_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> (copy_start && copy_whole));

    // R10: plus-one is terminal and freezes the mapped location.
    p_plus_one_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        plus_one |=> (plus_one && $stable(mapped_rank) && $stable(mapped_dev)));

    // R2: once valid, the mapped location never changes.
    p_map_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mapped_valid |=> (mapped_valid && $stable(mapped_rank) && $stable(mapped_dev)
                          && $stable(mapped_bank)));

    // R8: a conflicting adaptive configuration keeps the controller idle.
    p_conflict_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && cfg_adaptive_en && (cfg_x8 || cfg_mirror_en || cfg_rank_spare_en))
        |=> (mode == 3'd0));
endmodule

bind spare_escalation_ctrl spare_escalation_chk #(
    .RANK_W(RANK_W), .DEV_W(DEV_W), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_adaptive_en(cfg_adaptive_en), .cfg_x8(cfg_x8),
    .cfg_mirror_en(cfg_mirror_en), .cfg_rank_spare_en(cfg_rank_spare_en),
    .copy_done(copy_done), .mode(mode), .copy_start(copy_start), .copy_whole(copy_whole),
    .bank_vls(bank_vls), .rank_vls(rank_vls), .plus_one(plus_one),
    .mapped_valid(mapped_valid), .mapped_rank(mapped_rank), .mapped_dev(mapped_dev),
    .mapped_bank(mapped_bank)
);

// File: tb/test_spare_escalation_ctrl.sv
module test_spare_escalation_ctrl;
    localparam int RW = 3, DW = 5, BW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic a_en = 0, p_en = 0, x8 = 0, mir = 0, rsp = 0;
    logic sv = 0, done = 0;
    logic [RW-1:0] srank = '0;
    logic [DW-1:0] sdev = '0;
    logic [BW-1:0] sbank = '0;
    logic [2:0] mode;
    logic cstart, cwhole, bvls, rvls, p1, cerr, mv;
    logic [RW-1:0] mrank;
    logic [DW-1:0] mdev;
    logic [BW-1:0] mbank;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spare_escalation_ctrl #(.RANK_W(RW), .DEV_W(DW), .BANK_W(BW)) i_spare_escalation_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_adaptive_en(a_en), .cfg_plus_one_en(p_en),
        .cfg_x8(x8), .cfg_mirror_en(mir), .cfg_rank_spare_en(rsp),
        .strike_valid(sv), .strike_rank(srank), .strike_dev(sdev), .strike_bank(sbank),
        .copy_done(done), .mode(mode), .copy_start(cstart), .copy_whole(cwhole),
        .bank_vls(bvls), .rank_vls(rvls), .plus_one(p1), .cfg_err(cerr),
        .mapped_valid(mv), .mapped_rank(mrank), .mapped_dev(mdev), .mapped_bank(mbank));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; sv = 0; done = 0;
        a_en = 0; p_en = 0; x8 = 0; mir = 0; rsp = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    // One-cycle strike, sampled after the edge that takes it.
    task automatic strike(input int r, input int d, input int b);
        sv = 1; srank = RW'(r); sdev = DW'(d); sbank = BW'(b);
        tick();
        sv = 0;
    endtask

    task automatic pulse_done();
        done = 1; tick(); done = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 flags", {cstart, cwhole, bvls, rvls, p1, mv, cerr}, 0);

        // R8 R2 R6 R7 sweep over all configuration combinations
        for (int c = 0; c < 32; c++) begin
            bit ea, ep, ex, em, er, conf;
            int exp_mode;
            do_reset();
            {ea, ep, ex, em, er} = 5'(c);
            a_en = ea; p_en = ep; x8 = ex; mir = em; rsp = er;
            tick();
            conf = (ea && (ex || em || er)) || (ep && (em || er));
            exp_mode = conf ? 0 : (ea ? 1 : (ep ? 3 : 0));
            chk("R8 cfg_err sweep", cerr, conf);
            strike(1, 3, 2);
            chk("R2/R6/R7/R8 first strike mode sweep", mode, exp_mode);
        end

        // Adaptive path
        do_reset();
        a_en = 1; p_en = 1;
        strike(1, 3, 2);
        chk("R2 mode bank copy", mode, 1);
        chk("R2 mapped fields", {mv, mrank, mdev, mbank}, {1'b1, 3'd1, 5'd3, 4'd2});
        chk("R2 flags", {cstart, cwhole, bvls, rvls}, 4'b1010);
        tick(); tick();
        chk("R2 copy_start held", cstart, 1);
        pulse_done();
        chk("R2 bank lockstep", {mode, cstart, bvls}, {3'd2, 1'b0, 1'b1});
        strike(1, 9, 2);
        chk("R4 same bank ignored", mode, 2);
        strike(4, 3, 7);
        chk("R4 other rank ignored", mode, 2);
        pulse_done();
        chk("R11 stray done", mode, 2);
        strike(1, 7, 5);
        chk("R3 rank copy", mode, 3);
        chk("R3 flags", {cstart, cwhole, bvls, rvls}, 4'b1101);
        chk("R3 mapped kept", {mrank, mdev, mbank}, {3'd1, 5'd3, 4'd2});
        pulse_done();
        chk("R3 rank lockstep", mode, 4);
        strike(1, 3, 9);
        chk("R5 same device ignored", mode, 4);
        strike(2, 9, 0);
        chk("R5 other rank ignored", mode, 4);
        strike(1, 9, 0);
        chk("R5 plus one", {mode, p1}, {3'd5, 1'b1});
        done = 1; strike(1, 12, 6); done = 0;
        chk("R10 terminal", {mode, mdev, mbank}, {3'd5, 5'd3, 4'd2});

        // Plus-one disabled in rank lockstep
        do_reset();
        a_en = 1;
        strike(0, 4, 1); pulse_done();
        strike(0, 4, 3); pulse_done();
        chk("R5 reached rank lockstep", mode, 4);
        strike(0, 6, 3);
        chk("R5 plus-one disabled ignored", {mode, p1}, {3'd4, 1'b0});

        // Direct path
        do_reset();
        p_en = 1;
        strike(2, 5, 1);
        chk("R6 direct copy", {mode, cwhole, rvls}, {3'd3, 1'b1, 1'b0});
        pulse_done();
        chk("R6 straight to plus one", {mode, p1, rvls}, {3'd5, 1'b1, 1'b0});

        // Held strikes during copies
        do_reset();
        a_en = 1; p_en = 1;
        strike(1, 3, 2);
        strike(1, 3, 6);
        strike(1, 8, 7);
        chk("R9 still copying", mode, 1);
        pulse_done();
        chk("R9 bank lockstep first", mode, 2);
        tick();
        chk("R9 held strike promotes", mode, 3);
        pulse_done();
        chk("R9 rank lockstep", mode, 4);
        tick(); tick();
        chk("R9 second strike dropped", mode, 4);

        do_reset();
        a_en = 1; p_en = 1;
        strike(0, 1, 0); pulse_done();
        strike(0, 1, 4);
        strike(0, 8, 4);
        pulse_done();
        chk("R9 rank lockstep before held", mode, 4);
        tick();
        chk("R9 held strike enables plus one", mode, 5);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule